// File: doc/BRIEF.md
# Prioritized Display Interrupt Vector Controller

This block gathers four event sources from a segment display controller and reports them through one prioritized vector register and a single interrupt request line. The four events are a frame boundary, a blink-on transition, a blink-off transition, and a missing charge-pump capacitor. Each event has its own flag bit and its own enable bit. The vector names the most urgent event that is both flagged and enabled.

Software reaches the block through a small register bus with three registers. Each register is picked by a 2-bit address. Address 0 is the enable register and address 1 is the flag register. Address 2 is the vector register. In the enable and flag registers the bit positions are fixed:

- bit 0 is no-capacitor
- bit 1 is blink-off
- bit 2 is blink-on
- bit 3 is frame

Reads are combinational from the current state. A read of the vector returns the code and then clears the flag it named at the clock edge. A write of any value to the vector clears every flag.

The blink events follow a blink clock, and the 2-bit blink mode decides how they are raised. Any write into the display memory or the blink memory wipes the frame flag and both blink flags.

Top module: `disp_irq_vec`

## Requirements
- R1: After reset, the enable register, the flag register and the vector read 0, and irqReq is low.
- R2: The vector reads 0x02 when no-capacitor (bit 0) is the top pending source, 0x04 for blink-off (bit 1), 0x06 for blink-on (bit 2) and 0x08 for frame (bit 3). Lower bit means higher priority. The vector reads 0x00 when no enabled flag is set. A flag whose enable bit is 0 never affects the vector.
- R3: irqReq is high exactly when at least one flag is set with its enable bit also set.
- R4: A read strobe at address 2 clears only the flag the vector named, one cycle later. Other flags, including disabled ones, are kept, and irqReq stays high if another enabled flag remains.
- R5: A write strobe at address 2, with any data, clears all four flags.
- R6: A write at address 0 loads the enable bits from wdata[3:0]. A write at address 1 loads the flag bits from wdata[3:0], so software can clear single flags. A read at address 3 returns 0.
- R7: In blink modes 01 and 10, a rising blink-clock edge sets blink-on (bit 2) and a falling edge sets blink-off (bit 1).
- R8: In blink mode 11, an internal memory select starts at the main display memory and toggles on every blink-clock edge. An edge that selects the blink memory sets blink-on (bit 2). An edge that selects the main memory sets blink-off (bit 1). Outside mode 11 the select returns to the main memory.
- R9: In blink mode 00, blink-clock edges set neither blink flag.
- R10: A frameTick pulse sets the frame flag (bit 3).
- R11: The no-capacitor flag (bit 0) is set in every cycle where pumpEn is high and capPresent is low.
- R12: A dispMemWr or blinkMemWr strobe clears the frame, blink-on and blink-off flags and keeps the no-capacitor flag.
- R13: When a set event and any clear (bus or auto-clear) hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle frame boundary pulse |
| blinkClk | input | 1 | Blink clock, sampled on clk |
| blinkMode | input | 2 | Blink mode: 00 off, 01/10 edge, 11 memory swap |
| pumpEn | input | 1 | Charge pump enabled |
| capPresent | input | 1 | Capacitor detected on the pump pin |
| dispMemWr | input | 1 | Display memory write strobe |
| blinkMemWr | input | 1 | Blink memory write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (side effect at address 2 only) |
| busRdata | output | 8 | Read data, combinational |
| irqReq | output | 1 | Interrupt request |

## Verification
A flag register bit that is wrongly kept or wrongly dropped shows up in the flag read and in the vector one cycle after the event that should have changed it. In the same cycle, irqReq changes whenever that bit is enabled.

The memory select in mode 11 is hidden, but an error in it swaps which blink flag the next blink-clock edge raises. That shows up one cycle after the edge.

A wrong priority order shows only when two enabled flags are pending together, so the bench stacks flags before it reads the vector. It then confirms after the read that exactly the named bit was removed.

// File: rtl/dispirq_pkg.sv
package dispirq_pkg;
  localparam int NUM_SRC   = 4;
  localparam int SRC_NOCAP = 0;
  localparam int SRC_BOFF  = 1;
  localparam int SRC_BON   = 2;
  localparam int SRC_FRAME = 3;
  localparam int VEC_STEP  = 2;

  localparam int REG_EN   = 0;
  localparam int REG_FLAG = 1;
  localparam int REG_VEC  = 2;

  typedef struct packed {
    logic [NUM_SRC-1:0] setMask;
    logic               autoClr;
    logic               clrAll;
    logic               clrTop;
    logic               flagLoad;
    logic               enLoad;
  } strobe_t;
endpackage

// File: rtl/dispirq_ctrl.sv
module dispirq_ctrl
  import dispirq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              blinkClk,
  input  logic [1:0]        blinkMode,
  input  logic              pumpEn,
  input  logic              capPresent,
  input  logic              dispMemWr,
  input  logic              blinkMemWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(REG_EN);
  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(REG_FLAG);
  localparam logic [ADDR_W-1:0] ADDR_VEC  = ADDR_W'(REG_VEC);

  logic blinkPrev;
  logic memSel;
  logic memSelNext;
  logic blinkRise;
  logic blinkFall;
  logic blinkEdge;
  logic swapMode;
  logic normMode;

  assign blinkRise = blinkClk & ~blinkPrev;
  assign blinkFall = ~blinkClk & blinkPrev;
  assign blinkEdge = blinkRise | blinkFall;
  assign swapMode  = (blinkMode == 2'b11);
  assign normMode  = (blinkMode == 2'b01) || (blinkMode == 2'b10);

  // memSel = 1 means the blink memory drives the display
  always_comb begin
    if (!swapMode)      memSelNext = 1'b0;
    else if (blinkEdge) memSelNext = ~memSel;
    else                memSelNext = memSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blinkPrev <= 1'b0;
      memSel    <= 1'b0;
    end else begin
      blinkPrev <= blinkClk;
      memSel    <= memSelNext;
    end
  end

  always_comb begin
    stb = '0;
    stb.setMask[SRC_NOCAP] = pumpEn & ~capPresent;
    stb.setMask[SRC_FRAME] = frameTick;
    stb.setMask[SRC_BON]   = (normMode & blinkRise) | (swapMode & blinkEdge & ~memSel);
    stb.setMask[SRC_BOFF]  = (normMode & blinkFall) | (swapMode & blinkEdge & memSel);
    stb.autoClr  = dispMemWr | blinkMemWr;
    stb.enLoad   = busWr & (busAddr == ADDR_EN);
    stb.flagLoad = busWr & (busAddr == ADDR_FLAG);
    stb.clrAll   = busWr & (busAddr == ADDR_VEC);
    stb.clrTop   = busRd & (busAddr == ADDR_VEC);
  end

  // R8
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swapMode && blinkEdge) |=> (memSel != $past(memSel)));

  // R8
  swap_home_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swapMode |=> !memSel);

  // R9
  mode_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blinkMode == 2'b00) |-> (!stb.setMask[SRC_BON] && !stb.setMask[SRC_BOFF]));

  // R7
  norm_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (normMode && $rose(blinkClk)) |-> stb.setMask[SRC_BON]);
endmodule

// File: rtl/dispirq_dpath.sv
module dispirq_dpath
  import dispirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq
);
  localparam logic [NUM_SRC-1:0] AUTO_MASK = ~(NUM_SRC'(1) << SRC_NOCAP);

  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] topMask;
  logic [NUM_SRC-1:0] baseFlags;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] flagsNext;
  logic [DATA_W-1:0]  vecCode;
  logic               unusedHiBits;

  assign unusedHiBits = ^busWdata[DATA_W-1:NUM_SRC];
  assign pending      = flags & enReg;

  // lowest index wins: scan downward so the last hit is the lowest bit
  always_comb begin
    topMask = '0;
    vecCode = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        topMask    = '0;
        topMask[i] = 1'b1;
        vecCode    = DATA_W'((i + 1) * VEC_STEP);
      end
    end
  end

  always_comb begin
    baseFlags = stb.flagLoad ? busWdata[NUM_SRC-1:0] : flags;
    clrMask   = '0;
    if (stb.clrAll)  clrMask = '1;
    if (stb.clrTop)  clrMask = clrMask | topMask;
    if (stb.autoClr) clrMask = clrMask | AUTO_MASK;
    flagsNext = (baseFlags & ~clrMask) | stb.setMask;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[g] <= 1'b0;
        enReg[g] <= 1'b0;
      end else begin
        flags[g] <= flagsNext[g];
        if (stb.enLoad) enReg[g] <= busWdata[g];
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(REG_EN):   busRdata = DATA_W'(enReg);
      ADDR_W'(REG_FLAG): busRdata = DATA_W'(flags);
      ADDR_W'(REG_VEC):  busRdata = vecCode;
      default:           busRdata = '0;
    endcase
  end

  assign irqReq = |pending;

  // R5
  clr_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrAll && stb.setMask == '0) |=> (flags == '0));

  // R13
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMask != '0) |=> ((flags & $past(stb.setMask)) == $past(stb.setMask)));

  // R12
  auto_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.autoClr && !stb.flagLoad && stb.setMask == '0)
      |=> ((flags & AUTO_MASK) == '0));

  // R4
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrTop && pending != '0 && stb.setMask == '0 && !stb.flagLoad
      && !stb.autoClr && !stb.clrAll)
      |=> ($countones(flags) + 1 == $countones($past(flags))));

  // R2
  vec_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(topMask) && ((topMask & ~pending) == '0));
endmodule

// File: rtl/disp_irq_vec.sv
module disp_irq_vec
  import dispirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              blinkClk,
  input  logic [1:0]        blinkMode,
  input  logic              pumpEn,
  input  logic              capPresent,
  input  logic              dispMemWr,
  input  logic              blinkMemWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq
);
  strobe_t stb;

  dispirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameTick  (frameTick),
    .blinkClk   (blinkClk),
    .blinkMode  (blinkMode),
    .pumpEn     (pumpEn),
    .capPresent (capPresent),
    .dispMemWr  (dispMemWr),
    .blinkMemWr (blinkMemWr),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .stb        (stb)
  );

  dispirq_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqReq   (irqReq)
  );
endmodule

// File: tb/disp_irq_vec_tb.sv
module disp_irq_vec_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameTick = 1'b0;
  logic       blinkClk = 1'b0;
  logic [1:0] blinkMode = 2'b00;
  logic       pumpEn = 1'b0;
  logic       capPresent = 1'b1;
  logic       dispMemWr = 1'b0;
  logic       blinkMemWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdata;
  logic       irqReq;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_irq_vec u_dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .blinkClk(blinkClk),
    .blinkMode(blinkMode), .pumpEn(pumpEn), .capPresent(capPresent),
    .dispMemWr(dispMemWr), .blinkMemWr(blinkMemWr), .busAddr(busAddr),
    .busWdata(busWdata), .busWr(busWr), .busRd(busRd),
    .busRdata(busRdata), .irqReq(irqReq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic vecRead(output logic [7:0] d);
    @(negedge clk);
    busAddr = 2'd2; busRd = 1'b1;
    #1;
    d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic expectFlags(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    peek(2'd1, d);
    check(tag, d, exp);
  endtask

  task automatic setBlink(input logic v);
    @(negedge clk);
    blinkClk = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek(2'd0, d); check("R1 enable", d, 8'h00);
    peek(2'd1, d); check("R1 flags", d, 8'h00);
    peek(2'd2, d); check("R1 vector", d, 8'h00);
    check("R1 irq", {7'd0, irqReq}, 8'h00);
    peek(2'd3, d); check("R6 addr3", d, 8'h00);
  endtask

  task automatic t_frame_nocap;
    logic [7:0] d;
    regWrite(2'd0, 8'h0F);
    peek(2'd0, d); check("R6 enable load", d, 8'h0F);
    @(negedge clk); frameTick = 1'b1;
    @(negedge clk); frameTick = 1'b0;
    expectFlags("R10 frame", 8'h08);
    peek(2'd2, d); check("R2 frame vector", d, 8'h08);
    check("R3 irq frame", {7'd0, irqReq}, 8'h01);
    @(negedge clk); pumpEn = 1'b1; capPresent = 1'b0;
    @(negedge clk); capPresent = 1'b1;
    expectFlags("R11 nocap", 8'h09);
    peek(2'd2, d); check("R2 nocap priority", d, 8'h02);
    @(negedge clk); pumpEn = 1'b0;
  endtask

  task automatic t_read_clear;
    logic [7:0] d;
    vecRead(d); check("R4 read code", d, 8'h02);
    expectFlags("R4 top cleared", 8'h08);
    check("R4 irq stays", {7'd0, irqReq}, 8'h01);
    vecRead(d); check("R4 second code", d, 8'h08);
    expectFlags("R4 all cleared", 8'h00);
    check("R3 irq low", {7'd0, irqReq}, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    regWrite(2'd0, 8'h08);
    regWrite(2'd1, 8'h0F);
    expectFlags("R6 flag load", 8'h0F);
    peek(2'd2, d); check("R2 disabled ignored", d, 8'h08);
    vecRead(d); check("R4 read enabled only", d, 8'h08);
    expectFlags("R4 disabled kept", 8'h07);
    check("R3 irq none enabled", {7'd0, irqReq}, 8'h00);
    peek(2'd2, d); check("R2 none pending", d, 8'h00);
    regWrite(2'd0, 8'h06);
    peek(2'd2, d); check("R2 blinkoff over blinkon", d, 8'h04);
    regWrite(2'd0, 8'h0F);
  endtask

  task automatic t_write_vec;
    regWrite(2'd1, 8'h0F);
    regWrite(2'd2, 8'h5A);
    expectFlags("R5 write clears all", 8'h00);
    regWrite(2'd1, 8'h05);
    regWrite(2'd1, 8'h04);
    expectFlags("R6 single clear", 8'h04);
    regWrite(2'd2, 8'h00);
  endtask

  task automatic t_blink_norm;
    blinkMode = 2'b01;
    setBlink(1'b1);
    expectFlags("R7 rise mode01", 8'h04);
    regWrite(2'd2, 8'h00);
    setBlink(1'b0);
    expectFlags("R7 fall mode01", 8'h02);
    regWrite(2'd2, 8'h00);
    blinkMode = 2'b10;
    setBlink(1'b1);
    expectFlags("R7 rise mode10", 8'h04);
    setBlink(1'b0);
    regWrite(2'd2, 8'h00);
  endtask

  task automatic t_blink_swap;
    blinkMode = 2'b11;
    setBlink(1'b1);
    expectFlags("R8 to blink mem", 8'h04);
    regWrite(2'd2, 8'h00);
    setBlink(1'b0);
    expectFlags("R8 to main mem", 8'h02);
    regWrite(2'd2, 8'h00);
    setBlink(1'b1);
    expectFlags("R8 to blink mem again", 8'h04);
    regWrite(2'd2, 8'h00);
    blinkMode = 2'b00;
    setBlink(1'b0);
    blinkMode = 2'b11;
    setBlink(1'b1);
    expectFlags("R8 restart at main", 8'h04);
    regWrite(2'd2, 8'h00);
  endtask

  task automatic t_mode0;
    blinkMode = 2'b00;
    setBlink(1'b0);
    setBlink(1'b1);
    setBlink(1'b0);
    expectFlags("R9 mode00 silent", 8'h00);
  endtask

  task automatic t_autoclr;
    regWrite(2'd1, 8'h0F);
    @(negedge clk); dispMemWr = 1'b1;
    @(negedge clk); dispMemWr = 1'b0;
    expectFlags("R12 disp write", 8'h01);
    regWrite(2'd1, 8'h0E);
    @(negedge clk); blinkMemWr = 1'b1;
    @(negedge clk); blinkMemWr = 1'b0;
    expectFlags("R12 blink write", 8'h00);
  endtask

  task automatic t_setwins;
    @(negedge clk); frameTick = 1'b1; dispMemWr = 1'b1;
    @(negedge clk); frameTick = 1'b0; dispMemWr = 1'b0;
    expectFlags("R13 frame vs autoclr", 8'h08);
    @(negedge clk); frameTick = 1'b1; busAddr = 2'd2; busWr = 1'b1;
    @(negedge clk); frameTick = 1'b0; busWr = 1'b0;
    expectFlags("R13 frame vs vec write", 8'h08);
    regWrite(2'd2, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame_nocap();
    t_read_clear();
    t_disabled();
    t_write_vec();
    t_blink_norm();
    t_blink_swap();
    t_mode0();
    t_autoclr();
    t_setwins();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule